// File: doc/BRIEF.md
# Multiplexed-Bus Byte Memory Controller

This block links a byte-wide storage array to a microcontroller bus where the low address byte and the data share one set of eight lines. A strobe named `ale` marks the phase in which the address is on the bus. While that strobe is high, the array address follows the shared lines and the dedicated high-address pins. When the strobe falls, the block holds the address. After that, a read strobe or a write strobe acts on the held location.

Two read strobes are accepted: a program-fetch strobe and a data-read strobe. Because of this, one array answers in both the code space and the data space of a Harvard-style controller. If the write and data-read strobes are tied high, the block is a read-only code store.

A byte write is taken on the rising edge of the write strobe. It starts a busy interval of `BUSY_CYC` clock cycles that stands in for the time a nonvolatile cell needs to program. During that interval:
- every read returns a status byte in which bit 6 alternates from one read to the next;
- further writes are dropped.

Software can poll the status byte until two reads in a row match, which shows that the write has finished.

The read path is a three-state machine:
- **IDLE** waits for a qualified read, which is chip enable low and either read strobe low (transition IDLE→WAIT).
- **WAIT** counts `ACC_DLY` cycles. If the read strobe is released early, it goes back (WAIT→IDLE). When the count expires, it captures the byte or the status (WAIT→DRIVE).
- **DRIVE** drives the shared lines until the strobe is released (DRIVE→IDLE).

The shared lines are modelled as an output byte `ad_o` plus an enable `ad_oe`. When the enable is low, the lines are in high impedance.

Top module: `mux_bus_mem_ctrl`

## Requirements
- R1: While `ale` is high, the array address is `{addr_hi, ad_i}` taken live. A read performed with `ale` held high returns the byte at that live address.
- R2: When `ale` falls, the address is held. Later changes on `ad_i` or `addr_hi` do not move it until `ale` rises again.
- R3: A program-fetch read (`psen_n` low, `ce_n` low) keeps `ad_oe` low for the first `ACC_DLY` clock edges. At the `ACC_DLY+1`-th edge, `ad_oe` goes high and `ad_o` carries the addressed byte.
- R4: A data read (`rd_n` low, `ce_n` low) has the same timing as R3 and returns the same stored byte.
- R5: While `ce_n` is high, the block ignores all strobes. `ad_oe` stays 0, and a write strobe edge stores nothing.
- R6: `ad_oe` drops in the same cycle in which the read strobe is released. `ad_oe` is never high unless `ce_n` is low and a read strobe is low.
- R7: When `wr_n` rises while `ce_n` is low and no write is busy, the block stores the byte present on `ad_i` at the held address.
- R8: For `BUSY_CYC` cycles after an accepted write, every read returns a status byte. In that byte, bit 6 is 0 on the first read after the write and inverts on each later read, and all other bits are 0.
- R9: Once the busy interval has ended, reads return stored data again.
- R10: A write strobe edge during the busy interval leaves the array unchanged.
- R11: After reset, `ad_oe` is 0 and no write is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| ale | input | 1 | Address phase strobe; high = address passes through |
| psen_n | input | 1 | Program-fetch read strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write is taken on its rising edge |
| ad_i | input | LO_W | Shared lines as seen by the block (low address or write data) |
| addr_hi | input | HI_W | Dedicated high address inputs |
| ad_o | output | LO_W | Byte driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines; 0 = high impedance |

## Verification
The bench builds the block with `HI_W=3` (a 2 KiB array that stays small at elaboration), `ACC_DLY=2` and `BUSY_CYC=24`. With a short access delay, the bench can check the exact cycle in which `ad_oe` rises. With a busy window of 24 cycles, two complete status polls and one dropped write fit inside a single busy interval, and the end of that interval is then reached within a few cycles. The 11-bit address space lets randomly chosen locations reach both the high-address pins and the low byte, while a bench-side model array still tracks every stored byte.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2
    } rd_state_e;

    localparam int POLL_BIT = 6;
endpackage

// File: rtl/mbm_addr_latch.sv
module mbm_addr_latch #(
    parameter int LO_W = 8,
    parameter int HI_W = 7,
    localparam int AW  = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] lo_i,
    input  logic [HI_W-1:0] hi_i,
    output logic [AW-1:0]   addr_o
);
    logic [AW-1:0] held_q;
    logic [AW-1:0] live;

    assign live = {hi_i, lo_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (ale) begin
            held_q <= live;
        end
    end

    assign addr_o = ale ? live : held_q;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !$past(ale)) |-> $stable(addr_o)); // R2
endmodule

// File: rtl/mbm_array.sv
module mbm_array #(
    parameter int AW = 15,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/mbm_busy_timer.sv
module mbm_busy_timer #(
    parameter int CYC = 64,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CW'(CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

    AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8
endmodule

// File: rtl/mux_bus_mem_ctrl.sv
module mux_bus_mem_ctrl #(
    parameter int LO_W     = 8,
    parameter int HI_W     = 3,
    parameter int ACC_DLY  = 2,
    parameter int BUSY_CYC = 24,
    localparam int AW      = LO_W + HI_W,
    localparam int ACC_W   = (ACC_DLY > 1) ? $clog2(ACC_DLY) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            ale,
    input  logic            psen_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [LO_W-1:0] ad_i,
    input  logic [HI_W-1:0] addr_hi,
    output logic [LO_W-1:0] ad_o,
    output logic            ad_oe
);
    import mbm_pkg::*;

    rd_state_e       st_q, st_nxt;
    logic [AW-1:0]   arr_addr;
    logic [LO_W-1:0] arr_rdata;
    logic [ACC_W-1:0] acc_q;
    logic [LO_W-1:0] out_q;
    logic            tog_q;
    logic            wr_q;
    logic            busy;
    logic            rd_go;
    logic            wr_rise;
    logic            mem_we;
    logic            capture;
    logic [LO_W-1:0] status_byte;

    // address capture
    mbm_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ale(ale),
        .lo_i(ad_i), .hi_i(addr_hi), .addr_o(arr_addr)
    );

    // storage
    mbm_array #(.AW(AW), .DW(LO_W)) u_array (
        .clk(clk), .we(mem_we), .addr(arr_addr),
        .wdata(ad_i), .rdata(arr_rdata)
    );

    // write-busy interval
    mbm_busy_timer #(.CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(mem_we), .busy(busy)
    );

    assign rd_go   = !ce_n && (!psen_n || !rd_n);
    assign wr_rise = wr_n && !wr_q && !ce_n;
    assign mem_we  = wr_rise && !busy;
    assign capture = (st_q == ST_WAIT) && rd_go && (acc_q == '0);

    always_comb begin
        status_byte = '0;
        status_byte[POLL_BIT] = tog_q;
    end

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:  if (rd_go) st_nxt = ST_WAIT;
            ST_WAIT: begin
                if (!rd_go)            st_nxt = ST_IDLE;
                else if (acc_q == '0)  st_nxt = ST_DRIVE;
            end
            ST_DRIVE: if (!rd_go) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            acc_q <= '0;
            out_q <= '0;
            tog_q <= 1'b0;
            wr_q  <= 1'b1;
        end else begin
            st_q <= st_nxt;
            wr_q <= wr_n;
            if (st_q == ST_IDLE) begin
                acc_q <= ACC_W'(ACC_DLY - 1);
            end else if (st_q == ST_WAIT && acc_q != '0) begin
                acc_q <= acc_q - 1'b1;
            end
            if (capture) begin
                out_q <= busy ? status_byte : arr_rdata;
            end
            if (mem_we) begin
                tog_q <= 1'b0;
            end else if (capture && busy) begin
                tog_q <= ~tog_q;
            end
        end
    end

    // outputs
    always_comb begin
        ad_o  = out_q;
        ad_oe = (st_q == ST_DRIVE) && rd_go;
    end

    AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !ad_oe); // R5
    AST_DRIVE_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIVE && $past(st_q) != ST_DRIVE) |-> $past(st_q) == ST_WAIT); // R3
    AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy); // R8
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !mem_we); // R10
    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!psen_n || !rd_n)); // R6
endmodule

// File: tb/mux_bus_mem_ctrl_bench.sv
module mux_bus_mem_ctrl_bench;
    localparam int CLK_PER  = 10;
    localparam int LO_W     = 8;
    localparam int HI_W     = 3;
    localparam int ACC_DLY  = 2;
    localparam int BUSY_CYC = 24;
    localparam int AW       = LO_W + HI_W;
    localparam int DEPTH    = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [LO_W-1:0] ad_i = '0;
    logic [HI_W-1:0] addr_hi = '0;
    logic [LO_W-1:0] ad_o;
    logic ad_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #(CLK_PER/2) clk = ~clk;

    mux_bus_mem_ctrl #(.LO_W(LO_W), .HI_W(HI_W), .ACC_DLY(ACC_DLY), .BUSY_CYC(BUSY_CYC))
    u_mux_bus_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_i(ad_i), .addr_hi(addr_hi),
        .ad_o(ad_o), .ad_oe(ad_oe)
    );

    function automatic logic [7:0] poll_status(input bit tog);
        logic [7:0] s;
        s = 8'h00;
        s[6] = tog;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic latch_addr(input logic [AW-1:0] a);
        @(negedge clk);
        ce_n = 1'b0; ale = 1'b1;
        ad_i = a[LO_W-1:0]; addr_hi = a[AW-1:LO_W];
        @(negedge clk);
        ale = 1'b0;
        ad_i = ~a[LO_W-1:0]; addr_hi = ~a[AW-1:LO_W];
    endtask

    // strobe assumed released, ce low; ale state left as caller set it
    task automatic strobe_read(input bit use_rd, input string req, output logic [7:0] val);
        @(negedge clk);
        if (use_rd) rd_n = 1'b0; else psen_n = 1'b0;
        repeat (ACC_DLY) @(negedge clk);
        check({req, " oe low during access delay"}, 32'(ad_oe), 32'd0);
        @(negedge clk);
        check({req, " oe high after access delay"}, 32'(ad_oe), 32'd1);
        val = ad_o;
        rd_n = 1'b1; psen_n = 1'b1;
        #1;
        check("R6 oe drops with strobe", 32'(ad_oe), 32'd0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input bit expect_take);
        latch_addr(a);
        @(negedge clk);
        ad_i = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        if (expect_take) model[a] = d;
    endtask

    task automatic wait_idle();
        repeat (BUSY_CYC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [AW-1:0] a1, a2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R11 reset oe", 32'(ad_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 oe after reset", 32'(ad_oe), 32'd0);

        // R7 then R3/R4/R2
        a1 = 11'h5C3;
        do_write(a1, 8'h9E, 1'b1);
        wait_idle();
        latch_addr(a1);
        strobe_read(1'b0, "R3", v);
        check("R3 psen data / R2 held address", 32'(v), 32'(model[a1]));
        strobe_read(1'b1, "R4", v);
        check("R4 rd data / R7 stored", 32'(v), 32'(model[a1]));

        // R1: read with ale held high at live address
        a2 = 11'h0A7;
        do_write(a2, 8'h3C, 1'b1);
        wait_idle();
        @(negedge clk);
        ale = 1'b1; ad_i = a2[7:0]; addr_hi = a2[AW-1:LO_W];
        strobe_read(1'b0, "R1", v);
        check("R1 live address read", 32'(v), 32'h3C);
        @(negedge clk);
        ale = 1'b0;

        // R8 / R10 / R9
        do_write(a1, 8'h11, 1'b1);
        latch_addr(a1);
        strobe_read(1'b1, "R8", v);
        check("R8 first status poll", 32'(v), 32'(poll_status(1'b0)));
        strobe_read(1'b0, "R8", v);
        check("R8 second status poll", 32'(v), 32'(poll_status(1'b1)));
        do_write(a2, 8'hEE, 1'b0);
        wait_idle();
        latch_addr(a1);
        strobe_read(1'b1, "R9", v);
        check("R9 data after busy", 32'(v), 32'h11);
        latch_addr(a2);
        strobe_read(1'b0, "R10", v);
        check("R10 busy write dropped", 32'(v), 32'h3C);

        // R5: deselected strobes and write
        latch_addr(a2);
        @(negedge clk);
        ce_n = 1'b1; psen_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < ACC_DLY + 3; i++) begin
            @(negedge clk);
            check("R5 oe stays low with ce high", 32'(ad_oe), 32'd0);
        end
        psen_n = 1'b1; rd_n = 1'b1;
        ad_i = 8'h77; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        strobe_read(1'b1, "R5", v);
        check("R5 deselected write ignored, no busy", 32'(v), 32'h3C);

        // random write/read pairs
        for (int n = 0; n < 24; n++) begin
            logic [AW-1:0] ra;
            logic [7:0] rd;
            bit sel;
            ra  = AW'($urandom_range(0, DEPTH - 1));
            rd  = 8'($urandom);
            sel = 1'($urandom);
            do_write(ra, rd, 1'b1);
            wait_idle();
            latch_addr(ra);
            strobe_read(sel, sel ? "R4" : "R3", v);
            check(sel ? "R4 random readback" : "R3 random readback", 32'(v), 32'(model[ra]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule